// File: doc/BRIEF.md
# Programmable FIFO Threshold Flag Generator

This block derives the status flags of a FIFO from its binary write and read pointers: empty, full, more-than-half-full, almost-empty and almost-full. It holds no storage and no data path. The pointer pair is one bit wider than the address, so occupancy is their difference taken modulo twice the depth. The surrounding FIFO supplies the pointers and uses the flags to throttle its producer and consumer.

The two almost-flags each compare against an offset register. A master reset loads each offset from one of eight presets chosen by a 3-bit select input. It also latches a per-flag timing mode. After reset, software can reprogram both offsets in two ways. One is a single-bit shift interface that takes the almost-empty offset first and then the almost-full offset. The other is a word-wide interface whose strobes go to the two offsets in turn. A partial reset restarts both programming sequences and the flag registers, but keeps the offsets and modes. In synchronous mode an almost-flag is registered on its own port clock: the read clock for almost-empty and the write clock for almost-full. In asynchronous mode it follows the pointers combinationally.

Both resets are synchronous and active high. Both must be asserted for at least one edge of each clock.

Top module: `fifo_thresh_flags`

## Requirements
- R1: With occupancy = (wr_ptr − rd_ptr) mod 2·DEPTH, `empty` is 1 exactly when occupancy is 0, and `full` is 1 exactly when occupancy equals DEPTH. This holds for any pointer base, including wrapped pointers.
- R2: `half_full` is 1 exactly when occupancy is greater than DEPTH/2.
- R3: The almost-empty condition is occupancy ≤ the almost-empty offset. The almost-full condition is (DEPTH − occupancy) ≤ the almost-full offset.
- R4: On a write-clock edge with `mrst` high, each offset is loaded with ((sel+1)·DEPTH)/16. Here sel is `ae_sel` for the almost-empty offset and `af_sel` for the almost-full offset.
- R5: On a write-clock edge with `ser_en` high and `par_we` low, `ser_in` is written to bit k of a 2·AW-bit shift target. Bits 0..AW−1 are the almost-empty offset, LSB first, and bits AW..2·AW−1 are the almost-full offset, LSB first. k then advances, wrapping to 0 after bit 2·AW−1.
- R6: Each write-clock edge with `par_we` high writes `par_data` into the offsets in alternation: the almost-empty offset first, then the almost-full offset, then the almost-empty offset again.
- R7: When `par_we` and `ser_en` are high on the same edge, only the parallel write takes effect, and the serial bit position does not advance.
- R8: `prst` keeps both offsets and both timing modes. It returns the serial bit position and the parallel alternation to their starting points.
- R9: `mrst` latches `ae_async_sel` and `af_async_sel`, where 1 selects asynchronous timing. An asynchronous flag reflects its condition in the same cycle. A synchronous flag shows the condition as it stood at the previous edge of its port clock.
- R10: While `mrst` or `prst` is high, a synchronous `almost_empty` reads 1 and a synchronous `almost_full` reads 0.
- R11: Serial and parallel loads presented while `mrst` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock; clocks the offsets, the modes and the almost-full register |
| rclk | input | 1 | Read-port clock; clocks the almost-empty register |
| mrst | input | 1 | Master reset: loads presets and latches timing modes |
| prst | input | 1 | Partial reset: restarts sequences and keeps settings |
| wr_ptr | input | AW+1 | Binary write pointer |
| rd_ptr | input | AW+1 | Binary read pointer |
| ae_sel | input | 3 | Preset select for the almost-empty offset |
| af_sel | input | 3 | Preset select for the almost-full offset |
| ae_async_sel | input | 1 | Timing mode for almost-empty, sampled at master reset |
| af_async_sel | input | 1 | Timing mode for almost-full, sampled at master reset |
| ser_en | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial load data bit |
| par_we | input | 1 | Parallel load strobe |
| par_data | input | AW | Parallel load word |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals depth |
| half_full | output | 1 | Occupancy exceeds half the depth |
| almost_empty | output | 1 | Almost-empty flag |
| almost_full | output | 1 | Almost-full flag |

## Verification
The offsets and the load sequence position cannot be seen at the ports. They can only be inferred from where the almost-flags switch. The bench therefore follows every load with a full occupancy sweep from 0 to DEPTH, at varied pointer bases, so that both thresholds are located exactly. The hardest cases are a serial sequence cut off by a partial reset, and a simultaneous parallel and serial load. For these, the bench runs a complete serial load immediately afterwards. Any stale or advanced bit position then shows up as a misplaced threshold. Timing latency is exposed by changing the pointers between edges and sampling before the next edge.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  typedef enum logic {TM_SYNC = 1'b0, TM_ASYNC = 1'b1} tmode_e;

  // Occupancy of a FIFO whose pointers are pw bits wide (one extra wrap bit).
  function automatic int unsigned occupancy(int unsigned wr, int unsigned rd,
                                            int unsigned pw);
    return (wr - rd) & ((32'd1 << pw) - 32'd1);
  endfunction

  // Preset offset picked by a 3-bit select: eighths of half the depth.
  function automatic int unsigned preset_offset(logic [2:0] sel, int unsigned depth);
    return ((32'(sel) + 32'd1) * depth) / 32'd16;
  endfunction

endpackage

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import fifo_flag_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [2:0]    ae_sel,
  input  logic [2:0]    af_sel,
  input  logic          ae_async_sel,
  input  logic          af_async_sel,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic          par_we,
  input  logic [AW-1:0] par_data,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs,
  output tmode_e        ae_mode,
  output tmode_e        af_mode
);
  localparam int DEPTH    = 1 << AW;
  localparam int SER_BITS = 2 * AW;
  localparam int CNT_W    = $clog2(SER_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SER_BITS - 1);

  logic [SER_BITS-1:0] ofs_cat;   // {almost-full, almost-empty}
  logic [CNT_W-1:0]    ser_cnt;
  logic                par_seq;   // 0: next strobe to almost-empty

  // Named events for the assertions.
  logic ev_par_load, ev_ser_load;
  assign ev_par_load = par_we;
  assign ev_ser_load = ser_en && !par_we;

  always_ff @(posedge clk) begin
    if (mrst) begin
      ofs_cat <= {AW'(preset_offset(af_sel, DEPTH)), AW'(preset_offset(ae_sel, DEPTH))};
      ae_mode <= ae_async_sel ? TM_ASYNC : TM_SYNC;
      af_mode <= af_async_sel ? TM_ASYNC : TM_SYNC;
      ser_cnt <= '0;
      par_seq <= 1'b0;
    end else if (prst) begin
      ser_cnt <= '0;
      par_seq <= 1'b0;
    end else if (ev_par_load) begin
      if (par_seq) ofs_cat[SER_BITS-1:AW] <= par_data;
      else         ofs_cat[AW-1:0]        <= par_data;
      par_seq <= ~par_seq;
    end else if (ev_ser_load) begin
      ofs_cat[ser_cnt] <= ser_in;
      ser_cnt <= (ser_cnt == CNT_LAST) ? '0 : ser_cnt + 1'b1;
    end
  end

  assign ae_ofs = ofs_cat[AW-1:0];
  assign af_ofs = ofs_cat[SER_BITS-1:AW];

  AST_PAR_SEQ_ALTERNATES: assert property (@(posedge clk) disable iff (mrst || prst)
    ev_par_load |=> (par_seq != $past(par_seq))); // R6
  AST_SER_HOLD_ON_PAR: assert property (@(posedge clk) disable iff (mrst || prst)
    (ser_en && par_we) |=> $stable(ser_cnt)); // R7
  AST_PRST_KEEPS_OFS: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(ae_ofs) && $stable(af_ofs))); // R8
  AST_PRST_KEEPS_MODE: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(ae_mode) && $stable(af_mode))); // R8
  AST_SER_WRITES_BIT: assert property (@(posedge clk) disable iff (mrst || prst)
    ev_ser_load |=> (ofs_cat[$past(ser_cnt)] == $past(ser_in))); // R5

endmodule

// File: rtl/flag_timing.sv
module flag_timing #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_mode,
  input  logic cond,
  output logic flag
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= RST_VAL;
    else     cond_q <= cond;
  end

  assign flag = async_mode ? cond : cond_q;

  AST_SYNC_FLAG_LAGS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !async_mode) |-> (flag == $past(cond))); // R9
  AST_ASYNC_FLAG_NOW: assert property (@(posedge clk) disable iff (rst)
    async_mode |-> (flag == cond)); // R9

endmodule

// File: rtl/fifo_thresh_flags.sv
module fifo_thresh_flags
  import fifo_flag_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  input  logic [2:0]    ae_sel,
  input  logic [2:0]    af_sel,
  input  logic          ae_async_sel,
  input  logic          af_async_sel,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic          par_we,
  input  logic [AW-1:0] par_data,
  output logic          empty,
  output logic          full,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [1:0] FLAG_RST = 2'b01;  // index 0 almost-empty, 1 almost-full

  logic [AW-1:0] ae_ofs, af_ofs;
  tmode_e        ae_mode, af_mode;
  logic [PW-1:0] occ, free_cnt;

  flag_offset_prog #(.AW(AW)) u_prog (
    .clk(wclk), .mrst(mrst), .prst(prst),
    .ae_sel(ae_sel), .af_sel(af_sel),
    .ae_async_sel(ae_async_sel), .af_async_sel(af_async_sel),
    .ser_en(ser_en), .ser_in(ser_in), .par_we(par_we), .par_data(par_data),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_mode(ae_mode), .af_mode(af_mode)
  );

  assign occ      = PW'(occupancy(32'(wr_ptr), 32'(rd_ptr), PW));
  assign free_cnt = PW'(DEPTH) - occ;

  // Named condition wires.
  logic ev_empty, ev_full, ev_half, ae_cond, af_cond;
  assign ev_empty = (occ == '0);
  assign ev_full  = (occ == PW'(DEPTH));
  assign ev_half  = (occ > PW'(DEPTH / 2));
  assign ae_cond  = (occ <= {1'b0, ae_ofs});
  assign af_cond  = (free_cnt <= {1'b0, af_ofs});

  assign empty     = ev_empty;
  assign full      = ev_full;
  assign half_full = ev_half;

  logic [1:0] clk_v, cond_v, async_v, flag_v;
  assign clk_v   = {wclk, rclk};
  assign cond_v  = {af_cond, ae_cond};
  assign async_v = {af_mode == TM_ASYNC, ae_mode == TM_ASYNC};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    flag_timing #(.RST_VAL(FLAG_RST[g])) u_tim (
      .clk(clk_v[g]), .rst(mrst | prst), .async_mode(async_v[g]),
      .cond(cond_v[g]), .flag(flag_v[g])
    );
  end

  assign almost_empty = flag_v[0];
  assign almost_full  = flag_v[1];

  AST_FULL_IMPLIES_HALF: assert property (@(posedge wclk) disable iff (mrst)
    full |-> half_full); // R2
  AST_EMPTY_NOT_HALF: assert property (@(posedge rclk) disable iff (mrst)
    empty |-> !half_full); // R1
  AST_ASYNC_AE_ON_EMPTY: assert property (@(posedge rclk) disable iff (mrst || prst)
    (ae_mode == TM_ASYNC && empty) |-> almost_empty); // R3
  AST_ASYNC_AF_ON_FULL: assert property (@(posedge wclk) disable iff (mrst || prst)
    (af_mode == TM_ASYNC && full) |-> almost_full); // R3

endmodule

// File: tb/tb_fifo_thresh_flags.sv
module tb_fifo_thresh_flags;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PMOD  = 2 * DEPTH;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0;
  logic [AW:0] wr_ptr = '0, rd_ptr = '0;
  logic [2:0] ae_sel = '0, af_sel = '0;
  logic ae_async_sel = 1'b0, af_async_sel = 1'b0;
  logic ser_en = 1'b0, ser_in = 1'b0, par_we = 1'b0;
  logic [AW-1:0] par_data = '0;
  logic empty, full, half_full, almost_empty, almost_full;

  int nchk = 0, nerr = 0;
  int exp_ae, exp_af;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_thresh_flags #(.AW(AW)) dut (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ae_sel(ae_sel), .af_sel(af_sel),
    .ae_async_sel(ae_async_sel), .af_async_sel(af_async_sel),
    .ser_en(ser_en), .ser_in(ser_in), .par_we(par_we), .par_data(par_data),
    .empty(empty), .full(full), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_occ(int base, int occ);
    rd_ptr = (AW+1)'(base % PMOD);
    wr_ptr = (AW+1)'((base + occ) % PMOD);
  endtask

  // Steps occupancy 0..DEPTH; each value is held across one edge so that
  // both timing modes present the current condition.
  task automatic sweep(string req, int base);
    for (int occ = 0; occ <= DEPTH; occ++) begin
      set_occ(base, occ);
      tick();
      chk("R1", "empty", empty, occ == 0);
      chk("R1", "full", full, occ == DEPTH);
      chk("R2", "half_full", half_full, occ > DEPTH / 2);
      chk(req, "almost_empty", almost_empty, occ <= exp_ae);
      chk(req, "almost_full", almost_full, (DEPTH - occ) <= exp_af);
    end
  endtask

  task automatic do_mrst(int aes, int afs, logic aea, logic afa);
    ae_sel = 3'(aes); af_sel = 3'(afs);
    ae_async_sel = aea; af_async_sel = afa;
    mrst = 1'b1; tick(); tick(); mrst = 1'b0;
    exp_ae = ((aes + 1) * DEPTH) / 16;
    exp_af = ((afs + 1) * DEPTH) / 16;
  endtask

  task automatic ser_load(int aev, int afv);
    int word = (afv << AW) | aev;
    for (int i = 0; i < 2 * AW; i++) begin
      ser_en = 1'b1; ser_in = word[i]; tick();
    end
    ser_en = 1'b0;
  endtask

  task automatic par_load(int v);
    par_we = 1'b1; par_data = AW'(v); tick(); par_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    // Reset state and every preset, with mixed modes and pointer bases (R4, R3).
    do_mrst(0, 0, 1'b0, 1'b0);
    chk("R1", "reset empty", empty, 1'b1);
    chk("R10", "reset almost_empty", almost_empty, 1'b1);
    chk("R10", "reset almost_full", almost_full, 1'b0);
    for (int s = 0; s < 8; s++) begin
      do_mrst(s, 7 - s, s[0], s[1]);
      sweep("R4", s * 5);
    end

    // Timing modes (R9): ae sync, af async.
    do_mrst(0, 0, 1'b0, 1'b1);
    set_occ(3, 0); tick();
    set_occ(3, DEPTH); #1;
    chk("R9", "sync ae holds old value", almost_empty, 1'b1);
    chk("R9", "async af immediate", almost_full, 1'b1);
    tick();
    chk("R9", "sync ae after edge", almost_empty, 1'b0);
    // ae async, af sync.
    do_mrst(0, 0, 1'b1, 1'b0);
    set_occ(9, DEPTH); tick();
    set_occ(9, 0); #1;
    chk("R9", "async ae immediate", almost_empty, 1'b1);
    chk("R9", "sync af holds old value", almost_full, 1'b1);
    tick();
    chk("R9", "sync af after edge", almost_full, 1'b0);

    // Serial loading and wrap (R5).
    do_mrst(0, 0, 1'b0, 1'b0);
    ser_load(5, 3); exp_ae = 5; exp_af = 3; sweep("R5", 0);
    ser_load(1, 2); ser_load(10, 13); exp_ae = 10; exp_af = 13; sweep("R5", 21);

    // Parallel loading alternation (R6).
    par_load(9); par_load(12); exp_ae = 9; exp_af = 12; sweep("R6", 7);
    par_load(4); exp_ae = 4; sweep("R6", 30);
    par_load(7); exp_af = 7; sweep("R6", 2);

    // Partial reset keeps offsets and async mode, restarts sequences (R8).
    do_mrst(0, 0, 1'b1, 1'b0);
    par_load(2); exp_ae = 2;
    set_occ(0, DEPTH);
    prst = 1'b1; tick(); prst = 1'b0;
    sweep("R8", 11);
    set_occ(4, DEPTH); tick();
    set_occ(4, 0); #1;
    chk("R8", "async mode kept", almost_empty, 1'b1);
    par_load(6); exp_ae = 6; sweep("R8", 17);
    ser_en = 1'b1; ser_in = 1'b1; tick(); tick(); tick(); ser_en = 1'b0;
    prst = 1'b1; tick(); prst = 1'b0;
    ser_load(11, 5); exp_ae = 11; exp_af = 5; sweep("R8", 25);

    // Simultaneous parallel and serial load (R7).
    prst = 1'b1; tick(); prst = 1'b0;
    par_we = 1'b1; par_data = 4'd3; ser_en = 1'b1; ser_in = 1'b1; tick();
    par_we = 1'b0; ser_en = 1'b0;
    exp_ae = 3; sweep("R7", 6);
    ser_load(8, 9); exp_ae = 8; exp_af = 9; sweep("R7", 13);

    // Synchronous flag values during resets (R10).
    do_mrst(0, 0, 1'b0, 1'b0);
    set_occ(0, DEPTH); tick();
    chk("R10", "af before prst", almost_full, 1'b1);
    prst = 1'b1; tick();
    chk("R10", "sync ae during prst", almost_empty, 1'b1);
    chk("R10", "sync af during prst", almost_full, 1'b0);
    prst = 1'b0;
    mrst = 1'b1; tick();
    chk("R10", "sync af during mrst", almost_full, 1'b0);
    mrst = 1'b0;

    // Loads during master reset are ignored (R11).
    ae_sel = 3'd6; af_sel = 3'd1; ae_async_sel = 1'b0; af_async_sel = 1'b1;
    par_we = 1'b1; par_data = 4'd15; ser_en = 1'b1; ser_in = 1'b1;
    mrst = 1'b1; tick(); tick(); mrst = 1'b0;
    par_we = 1'b0; ser_en = 1'b0;
    exp_ae = 7; exp_af = 2;
    sweep("R11", 19);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule